// File: doc/BRIEF.md
# Dual-Mode Waveform Playback Engine

This block supplies 8-bit samples to a DAC from an on-chip waveform table. The table holds one full cycle of a waveform, stored in address order. A host loads the table, picks one of two playback modes, and sets the parameters for that mode. It then raises `play_en`. While `play_en` is high, one sample is produced on every clock, and `sample_valid` marks each one. The engine runs on the same clock as the DAC.

In counter mode, an address counter starts at zero and advances by one on every clock. After a programmable last address it returns to zero, so the table can hold a waveform shorter than its full depth. In synthesis mode, a 24-bit phase accumulator adds a programmable increment on every clock. Its eight most significant bits address the table. The output frequency therefore follows the increment, and a new increment takes effect without any break in phase.

Top module: `wave_player`

## Requirements
- R1: After a synchronous reset, `sample_valid` is 0 and `sample_out` is 0. The increment resets to 0 and the last address resets to 255.
- R2: A host write (`host_wr_en`) while `play_en` is low stores `host_wr_data` at `host_wr_addr`. A host write while `play_en` is high leaves the table unchanged.
- R3: `sample_valid` equals `play_en` from one clock earlier. Every clock with `play_en` high yields exactly one sample, one clock later.
- R4: Counter mode is `mode_sel`=0. The first sample after `play_en` rises comes from address 0, and each later sample comes from the next address up.
- R5: In counter mode, the sample after the one from the last address comes from address 0. A write of `last_data` with `last_wr` while idle sets the last address. A write while playing is ignored.
- R6: Synthesis mode is `mode_sel`=1. The accumulator starts at 0 when play starts, reads the table at accumulator bits [23:16], then adds the increment, modulo 2^24.
- R7: An increment written with `inc_wr` on clock k is first added on clock k+1. The clock-k addition still uses the old increment, and the accumulator is never cleared by the write.
- R8: While `play_en` is low, `sample_out` keeps the last sample produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the DAC |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Table write strobe |
| host_wr_addr | input | 8 | Table write address |
| host_wr_data | input | 8 | Table write data |
| mode_sel | input | 1 | 0 counter mode, 1 synthesis mode |
| inc_wr | input | 1 | Load phase increment |
| inc_data | input | 24 | Phase increment value |
| last_wr | input | 1 | Load counter last address |
| last_data | input | 8 | Counter last address value |
| play_en | input | 1 | Playback enable |
| sample_out | output | 8 | Sample word to the DAC |
| sample_valid | output | 1 | Marks a new sample on `sample_out` |

## Verification
The checks assume that `mode_sel` changes only while `play_en` is low. They also assume that reset is held for at least one clock before any other activity. The stimulus changes the mode and loads the table only between play bursts. Increment writes, blocked table writes and blocked last-address writes are issued in the middle of bursts to exercise the gating. All inputs are driven on the falling edge, so every rising edge sees stable values.

// File: rtl/wave_pkg.sv
package wave_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SYNTH = 1'b1
  } play_mode_e;
endpackage

// File: rtl/wave_ram.sv
module wave_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port, no reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  assert_ram_store_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              last_wr,
  input  logic [ADDR_W-1:0] last_data,
  output logic [ADDR_W-1:0] cnt
);
  localparam logic [ADDR_W-1:0] LAST_RST = '1;

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst)          last_q <= LAST_RST;
    else if (last_wr) last_q <= last_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !en)        cnt_q <= '0;
    else if (cnt_q == last_q) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  assert_seq_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_q);
  assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_q != last_q) |=> cnt_q == ADDR_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              inc_wr,
  input  logic [ACC_W-1:0]  inc_data,
  output logic [ADDR_W-1:0] phase_addr
);
  localparam int FRAC_W = ACC_W - ADDR_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] inc_q;

  always_ff @(posedge clk) begin
    if (rst)         inc_q <= '0;
    else if (inc_wr) inc_q <= inc_data;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) acc_q <= '0;
    else            acc_q <= acc_q + inc_q;
  end

  assign phase_addr = acc_q[ACC_W-1:FRAC_W];

  assert_phase_cont_R7: assert property (@(posedge clk) disable iff (rst)
    (en && inc_wr) |=> acc_q == ACC_W'($past(acc_q) + $past(inc_q)));
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [DATA_W-1:0] host_wr_data,
  input  logic              mode_sel,
  input  logic              inc_wr,
  input  logic [ACC_W-1:0]  inc_data,
  input  logic              last_wr,
  input  logic [ADDR_W-1:0] last_data,
  input  logic              play_en,
  output logic [DATA_W-1:0] sample_out,
  output logic              sample_valid
);
  play_mode_e        mode;
  logic [ADDR_W-1:0] cnt_addr;
  logic [ADDR_W-1:0] dds_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              valid_q;
  logic              chk_arm;

  assign mode = play_mode_e'(mode_sel);

  seq_counter #(.ADDR_W(ADDR_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .en        (play_en && mode == MODE_COUNT),
    .last_wr   (last_wr && !play_en),
    .last_data (last_data),
    .cnt       (cnt_addr)
  );

  phase_accum #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .en         (play_en && mode == MODE_SYNTH),
    .inc_wr     (inc_wr),
    .inc_data   (inc_data),
    .phase_addr (dds_addr)
  );

  assign rd_addr = (mode == MODE_SYNTH) ? dds_addr : cnt_addr;

  wave_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr_en && !play_en),
    .wr_addr (host_wr_addr),
    .wr_data (host_wr_data),
    .rd_en   (play_en),
    .rd_addr (rd_addr),
    .rd_data (sample_out)
  );

  // strobe delayed to line up with the registered table read
  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= play_en;
  end
  assign sample_valid = valid_q;

  always_ff @(posedge clk) chk_arm <= !rst;

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_arm && !play_en) |=> $stable(sample_out));
  assert_valid_align_R3: assert property (@(posedge clk) disable iff (rst)
    chk_arm |-> sample_valid == $past(play_en));
endmodule

// File: tb/test_wave_player.sv
`timescale 1ns/1ps
module test_wave_player;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr_en;
  logic [7:0]  host_wr_addr;
  logic [7:0]  host_wr_data;
  logic        mode_sel;
  logic        inc_wr;
  logic [23:0] inc_data;
  logic        last_wr;
  logic [7:0]  last_data;
  logic        play_en;
  logic [7:0]  sample_out;
  logic        sample_valid;

  always #2 clk = ~clk;

  wave_player i_wave_player (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .mode_sel(mode_sel), .inc_wr(inc_wr),
    .inc_data(inc_data), .last_wr(last_wr), .last_data(last_data),
    .play_en(play_en), .sample_out(sample_out), .sample_valid(sample_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0]  ram_m [256];
  logic [7:0]  m_cnt, m_last;
  logic [23:0] m_acc, m_inc;
  logic [7:0]  last_pushed;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected samples as valid ones appear
  always @(negedge clk) begin
    if (!rst && !done && sample_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected sample", sample_out, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sample_out == e, t, sample_out, e);
      end
    end
  end

  // driver: one playing clock, pushes the sample it should read
  task automatic play_one(input string tag);
    logic [7:0] a;
    play_en = 1'b1;
    a = mode_sel ? m_acc[23:16] : m_cnt;
    exp_q.push_back(ram_m[a]);
    tag_q.push_back(tag);
    last_pushed = ram_m[a];
    if (mode_sel) m_acc = m_acc + m_inc;
    else          m_cnt = (m_cnt == m_last) ? 8'd0 : m_cnt + 8'd1;
    @(negedge clk);
  endtask

  task automatic play_n(input int n, input string tag);
    for (int i = 0; i < n; i++) play_one(tag);
  endtask

  task automatic stop_play();
    play_en = 1'b0;
    m_cnt = 8'd0;
    m_acc = 24'd0;
    @(negedge clk);
    chk(sample_valid == 1'b0, "R3 valid drop", sample_valid, 0);
    chk(exp_q.size() == 0, "R3 pending samples", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(sample_out == last_pushed, "R8 idle hold", sample_out, last_pushed);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    ram_m[a] = d;
  endtask

  task automatic set_last(input logic [7:0] v);
    last_wr = 1'b1; last_data = v;
    @(negedge clk);
    last_wr = 1'b0;
    m_last = v;
  endtask

  task automatic set_inc(input logic [23:0] v);
    inc_wr = 1'b1; inc_data = v;
    @(negedge clk);
    inc_wr = 1'b0;
    m_inc = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; host_wr_en = 0; host_wr_addr = 0; host_wr_data = 0;
    mode_sel = 0; inc_wr = 0; inc_data = 0; last_wr = 0; last_data = 0; play_en = 0;
    m_cnt = 0; m_acc = 0; m_inc = 0; m_last = 8'hFF; last_pushed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(sample_valid == 1'b0, "R1 reset valid", sample_valid, 0);
    chk(sample_out == 8'h00, "R1 reset sample", sample_out, 0);

    // R2: load the whole table while idle
    for (int i = 0; i < 256; i++) host_write(8'(i), 8'(i * 7 + 3));

    // R4/R5: counter mode with reset last address 255, wraps once
    mode_sel = 1'b0;
    play_n(300, "R4 R5 count wrap at 255");
    stop_play();

    // R5: short loop, then a last-address write during play is ignored
    set_last(8'd9);
    play_n(12, "R5 loop of 10");
    last_wr = 1'b1; last_data = 8'd3;
    play_one("R5 last write while playing");
    last_wr = 1'b0;
    play_n(15, "R5 loop unchanged");
    stop_play();

    // R5: single-entry loop
    set_last(8'd0);
    play_n(4, "R5 last address 0");
    // R2: write attempt during play is dropped
    host_wr_en = 1'b1; host_wr_addr = 8'd0; host_wr_data = 8'hEE;
    play_one("R2 write while playing");
    host_wr_en = 1'b0;
    play_n(3, "R2 table unchanged");
    stop_play();
    host_write(8'd0, 8'hC5);
    play_n(3, "R2 idle write lands");
    stop_play();

    // R6: synthesis mode, one address per clock
    set_last(8'hFF);
    mode_sel = 1'b1;
    set_inc(24'h010000);
    play_n(20, "R6 step one");
    stop_play();
    // R6: fractional step and wrap of the accumulator
    set_inc(24'h008000);
    play_n(10, "R6 half step");
    stop_play();
    set_inc(24'hF12345);
    play_n(40, "R6 large step wrap");
    // R7: increment change mid play, phase continues
    inc_wr = 1'b1; inc_data = 24'h030000;
    play_one("R7 old increment on write clock");
    inc_wr = 1'b0;
    m_inc = 24'h030000;
    play_n(30, "R7 new increment");
    inc_wr = 1'b1; inc_data = 24'h000400;
    play_one("R7 second change");
    inc_wr = 1'b0;
    m_inc = 24'h000400;
    play_n(20, "R7 slow increment");
    stop_play();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule